// File: doc/BRIEF.md
# Hysteretic Threshold Discriminator

This block watches a stream of 16-bit digitized samples and decides, one sample at a time, whether the signal is beyond a programmable threshold. It drives two outputs. `tot` is a level gate that stays high while the signal is over threshold, so the length of the gate is the pulse's time over threshold. `trigger` is a single-cycle strobe that marks the leading edge of each pulse. A polarity input chooses between positive-going and negative-going pulses. A separate delta input sets a hysteresis margin, so the gate closes only after the signal has moved back past the threshold by that margin. This keeps noise riding on the threshold from splitting one pulse into several triggers.

Downstream logic typically uses `trigger` to latch a timestamp and the falling edge of `tot` to commit a duration measurement. Threshold, polarity and delta are taken from the inputs only while the gate is closed. While a gate is open they are held, so reprogramming during a pulse cannot cut that pulse short. A parameter selects whether samples and the threshold are read as unsigned or as two's complement values.

Top module: `thr_hyst_trigger`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tot` and `trigger` are 0 after that edge. This holds even if a gate was open.
- R2: With `polarity` = 0 and the gate closed, a valid sample that satisfies sample >= threshold sets `tot` to 1 after the next clock edge.
- R3: With `polarity` = 0 and the gate open, a valid sample with sample < threshold − delta clears `tot` after the next edge. Valid samples from threshold − delta up to threshold − 1 leave `tot` at 1.
- R4: With `polarity` = 1 and the gate closed, a valid sample that satisfies sample <= threshold sets `tot` after the next edge.
- R5: With `polarity` = 1 and the gate open, a valid sample with sample > threshold + delta clears `tot`. Valid samples from threshold + 1 up to threshold + delta leave `tot` at 1.
- R6: `trigger` is 1 for exactly one cycle, the cycle in which `tot` goes from 0 to 1. `trigger` is 0 in every other cycle, including while the gate stays open.
- R7: A cycle with `sample_valid` = 0 changes neither `tot` nor `trigger`. After such a cycle `trigger` is 0.
- R8: Threshold, polarity and delta are taken from the inputs in every cycle in which `tot` is 0. While `tot` is 1, the values captured in the last cycle with `tot` = 0 are used, and changes on the inputs have no effect until the gate closes.
- R9: threshold − delta and threshold + delta are computed at full range without wraparound. If the release level lies outside the sample range, the gate cannot close.
- R10: With parameter `SIGNED_SAMPLES` = 1, `sample` and `threshold` are compared as two's complement values. With 0 they are compared as unsigned values. `delta` is always unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 16 | Digitized input sample |
| sample_valid | input | 1 | High when `sample` carries a new value |
| threshold | input | 16 | Threshold level |
| polarity | input | 1 | 0: positive-going pulses; 1: negative-going pulses |
| delta | input | 16 | Unsigned hysteresis margin for release |
| trigger | output | 1 | One-cycle leading-edge strobe |
| tot | output | 1 | Time-over-threshold gate |

## Verification
The bench targets the edges of the hysteresis band: the exact threshold, threshold − delta, and one count past it. A design with an off-by-one comparison there would open a gate late or close it one sample early. It also moves the threshold while a gate is open. A design that does not hold its configuration would close that gate at once on the new level. Release levels that fall outside the sample range are exercised in both signed and unsigned builds. A design that wraps threshold ± delta would close gates at random in those cases. Stalls on `sample_valid` and a reset in mid-pulse catch a design that counts invalid samples or leaves a stale trigger behind.

// File: rtl/thr_trig_pkg.sv
package thr_trig_pkg;

    localparam int TT_W = 16;

    typedef enum logic {
        POL_RISING  = 1'b0,
        POL_FALLING = 1'b1
    } pol_e;

    typedef struct packed {
        logic [TT_W-1:0] level;
        logic [TT_W-1:0] margin;
        pol_e            dir;
    } trig_cfg_t;

endpackage

// File: rtl/thr_cfg_hold.sv
module thr_cfg_hold
    import thr_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      gate_open,
    input  trig_cfg_t live_cfg,
    output trig_cfg_t eff_cfg
);

    trig_cfg_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (!gate_open) begin
            held_q <= live_cfg;
        end
    end

    assign eff_cfg = gate_open ? held_q : live_cfg;

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_open && $past(gate_open)) |-> $stable(eff_cfg));

endmodule

// File: rtl/thr_cmp.sv
module thr_cmp
    import thr_trig_pkg::*;
#(
    parameter bit SIGNED_SAMPLES = 1'b0,
    parameter int W              = TT_W
) (
    input  logic [W-1:0] smp,
    input  trig_cfg_t    cfg,
    output logic         set_hit,
    output logic         rel_hit
);

    localparam int EW = W + 2;

    logic signed [EW-1:0] s_e, t_e, d_e, lo_e, hi_e;

    generate
        if (SIGNED_SAMPLES) begin : g_signed
            assign s_e = {{2{smp[W-1]}}, smp};
            assign t_e = {{2{cfg.level[W-1]}}, cfg.level};
        end else begin : g_unsigned
            assign s_e = {2'b00, smp};
            assign t_e = {2'b00, cfg.level};
        end
    endgenerate

    assign d_e  = {2'b00, cfg.margin};
    assign lo_e = t_e - d_e;
    assign hi_e = t_e + d_e;

    always_comb begin
        if (cfg.dir == POL_FALLING) begin
            set_hit = (s_e <= t_e);
            rel_hit = (s_e >  hi_e);
        end else begin
            set_hit = (s_e >= t_e);
            rel_hit = (s_e <  lo_e);
        end
    end

    // R9
    band_order_chk: assert final (lo_e <= t_e && t_e <= hi_e);

endmodule

// File: rtl/thr_hyst_trigger.sv
module thr_hyst_trigger
    import thr_trig_pkg::*;
#(
    parameter bit SIGNED_SAMPLES = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TT_W-1:0] sample,
    input  logic            sample_valid,
    input  logic [TT_W-1:0] threshold,
    input  logic            polarity,
    input  logic [TT_W-1:0] delta,
    output logic            trigger,
    output logic            tot
);

    trig_cfg_t live_cfg, eff_cfg;
    logic      tot_q, trig_q;
    logic      set_hit, rel_hit;

    assign live_cfg.level  = threshold;
    assign live_cfg.margin = delta;
    assign live_cfg.dir    = pol_e'(polarity);

    thr_cfg_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .gate_open (tot_q),
        .live_cfg  (live_cfg),
        .eff_cfg   (eff_cfg)
    );

    thr_cmp #(
        .SIGNED_SAMPLES (SIGNED_SAMPLES),
        .W              (TT_W)
    ) u_cmp (
        .smp     (sample),
        .cfg     (eff_cfg),
        .set_hit (set_hit),
        .rel_hit (rel_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            if (sample_valid) begin
                if (!tot_q && set_hit) begin
                    tot_q  <= 1'b1;
                    trig_q <= 1'b1;
                end else if (tot_q && rel_hit) begin
                    tot_q  <= 1'b0;
                end
            end
        end
    end

    assign tot     = tot_q;
    assign trigger = trig_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!tot && !trigger));

    // R6
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        trigger |=> !trigger);

    // R6
    trig_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tot) |-> trigger);

    // R6
    trig_needs_gate_chk: assert property (@(posedge clk) disable iff (rst)
        trigger |-> (tot && !$past(tot)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(tot) && !trigger));

endmodule

// File: tb/thr_hyst_trigger_tb.sv
module thr_hyst_trigger_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] sample = '0;
    logic        sample_valid = 1'b0;
    logic [15:0] threshold = '0;
    logic        polarity = 1'b0;
    logic [15:0] delta = '0;
    logic        trig_u, tot_u, trig_s, tot_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    thr_hyst_trigger #(.SIGNED_SAMPLES(1'b0)) dut_i (
        .clk(clk), .rst(rst), .sample(sample), .sample_valid(sample_valid),
        .threshold(threshold), .polarity(polarity), .delta(delta),
        .trigger(trig_u), .tot(tot_u)
    );

    thr_hyst_trigger #(.SIGNED_SAMPLES(1'b1)) dut_s_i (
        .clk(clk), .rst(rst), .sample(sample), .sample_valid(sample_valid),
        .threshold(threshold), .polarity(polarity), .delta(delta),
        .trigger(trig_s), .tot(tot_s)
    );

    typedef struct {
        bit tot;
        bit trig;
        int thr;
        bit pol;
        int dl;
    } mstate_t;

    mstate_t mu, ms;

    function automatic int conv(logic [15:0] x, bit sgn);
        return sgn ? int'($signed(x)) : int'(x);
    endfunction

    function automatic mstate_t mstep(mstate_t s, bit sgn);
        mstate_t n = s;
        int t, d, v;
        bit p;
        if (rst) begin
            n.tot = 0; n.trig = 0;
            return n;
        end
        if (!s.tot) begin
            n.thr = conv(threshold, sgn);
            n.pol = polarity;
            n.dl  = int'(delta);
        end
        t = s.tot ? s.thr : conv(threshold, sgn);
        p = s.tot ? s.pol : polarity;
        d = s.tot ? s.dl  : int'(delta);
        v = conv(sample, sgn);
        n.trig = 0;
        if (sample_valid) begin
            if (!s.tot && (p ? (v <= t) : (v >= t))) begin
                n.tot = 1; n.trig = 1;
            end else if (s.tot && (p ? (v > t + d) : (v < t - d))) begin
                n.tot = 0;
            end
        end
        return n;
    endfunction

    task automatic check(string req, string what, bit got, bit exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic apply(string req, bit r, bit v, int smp, int thr, bit pol, int dl);
        rst = r; sample_valid = v; sample = smp[15:0];
        threshold = thr[15:0]; polarity = pol; delta = dl[15:0];
        @(posedge clk);
        mu = mstep(mu, 1'b0);
        ms = mstep(ms, 1'b1);
        @(negedge clk);
        check(req, "unsigned tot", tot_u, mu.tot);
        check(req, "unsigned trigger", trig_u, mu.trig);
        check(req, "signed tot", tot_s, ms.tot);
        check(req, "signed trigger", trig_s, ms.trig);
    endtask

    initial begin
        mu = '{0, 0, 0, 0, 0};
        ms = '{0, 0, 0, 0, 0};
        @(negedge clk);
        apply("R1", 1, 0, 0, 0, 0, 0);
        apply("R1", 1, 1, 500, 100, 0, 10);
        // polarity 0, threshold 100, delta 10
        apply("R2", 0, 1, 50, 100, 0, 10);
        apply("R2", 0, 1, 99, 100, 0, 10);
        apply("R2", 0, 1, 100, 100, 0, 10);
        apply("R6", 0, 1, 200, 100, 0, 10);
        apply("R3", 0, 1, 95, 100, 0, 10);
        apply("R3", 0, 1, 90, 100, 0, 10);
        apply("R7", 0, 0, 0, 100, 0, 10);
        apply("R8", 0, 1, 500, 1000, 0, 10);
        apply("R3", 0, 1, 89, 1000, 0, 10);
        apply("R8", 0, 1, 500, 1000, 0, 10);
        apply("R8", 0, 1, 1000, 1000, 0, 10);
        apply("R1", 1, 1, 1000, 1000, 0, 10);
        // polarity 1, threshold 200, delta 5
        apply("R4", 0, 1, 300, 200, 1, 5);
        apply("R4", 0, 1, 200, 200, 1, 5);
        apply("R5", 0, 1, 205, 200, 1, 5);
        apply("R7", 0, 0, 9999, 200, 1, 5);
        apply("R5", 0, 1, 206, 200, 1, 5);
        // no wraparound, signed vs unsigned interpretation
        apply("R9", 0, 1, 5, 5, 0, 10);
        apply("R9", 0, 1, 0, 5, 0, 10);
        apply("R10", 0, 1, 16'hFFF0, 5, 0, 10);
        apply("R1", 1, 0, 0, 0, 0, 0);
        apply("R9", 0, 1, 16'hFFF0, 16'hFFF0, 1, 16'h0020);
        apply("R9", 0, 1, 16'hFFFF, 16'hFFF0, 1, 16'h0020);
        apply("R10", 0, 1, 16'h0020, 16'hFFF0, 1, 16'h0020);
        apply("R1", 1, 0, 0, 0, 0, 0);
        // constrained random around two threshold regions
        for (int i = 0; i < 4000; i++) begin
            int base, thr, smp, dl;
            bit pol, v, r;
            base = (i < 2000) ? 32'h8000 : 32'h0000;
            thr  = base + int'($urandom_range(0, 40)) - 20;
            dl   = int'($urandom_range(0, 12));
            smp  = thr + int'($urandom_range(0, 60)) - 30;
            pol  = ($urandom_range(0, 99) < 10) ? ~mu.pol : mu.pol;
            v    = ($urandom_range(0, 99) < 80);
            r    = ($urandom_range(0, 999) < 3);
            apply("R6", r, v, smp & 32'hFFFF, thr & 32'hFFFF, pol, dl);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule